// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a set of 64-bit event counters for a processor core. Each counter slot takes one event pulse line. It adds one on every clock edge where its event is high and counting is allowed. Counting is allowed only when the global start bit is set, the slot's own enable bit is set, and the privilege mode of the core permits it. A supervisor-mode permit bit and a user-mode permit bit each decide for their own mode.

Software reaches the bank through a single 32-bit word port with a write strobe. A space select picks one of two address spaces. The control space holds the control word at word 0 and the count-enable word at word 1. The counter space shows each counter as two 32-bit halves. The halves are live and have no snapshot latch. A reader must therefore read high, then low, then high again, and retry if the two high reads differ. Software loads a counter by writing its halves, and it can clear all counters or all enables in one write.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter half, the control word and the count-enable word read 0.
- R2: In the counter space, counter n has its low 32 bits at word address 2n and its high 32 bits at 2n+1. A read returns the current live value through the combinational `rd_data`.
- R3: Counter n adds exactly one on a clock edge if and only if all of these are 1 at that edge: `evt_in[n]`, enable bit n, control bit 0 (run), and the permit bit for the current mode.
- R4: Control bit 2 permits counting while `priv_sup` is 1 (supervisor). Control bit 3 permits counting while `priv_sup` is 0 (user).
- R5: Count-enable bit n gates counter n alone. The word reads back as written, limited to the implemented slots.
- R6: A write to a counter half replaces that half at the edge. It takes priority over an increment of the same counter at the same edge.
- R7: Writing control with bit 31 set clears every counter. Writing control with bit 30 set clears the count-enable word. Bits 31 and 30 always read 0, and bits 29..0 read back as written.
- R8: Only slots 1 to 27 (0x1b) exist, and slot 9 is also absent. The absent slots are 0, 9 and 28 to 31. They read 0, ignore writes and events, and their enable bits read 0.
- R9: A carry out of the low half increments the high half at the same edge.
- R10: Writing control with the value 0x2 stops every counter. The control word then reads back 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| space_sel | input | 1 | 0 selects the control space, 1 selects the counter space |
| addr | input | 6 | Word address within the selected space |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `space_sel`/`addr` |
| evt_in | input | 32 | Event pulse per slot |
| priv_sup | input | 1 | 1 while the core runs in supervisor mode, 0 in user mode |

## Verification
Event bursts are applied to a single slot and to several slots at once. Each burst runs under a different run bit, permit bit and privilege mode, so a wrong qualifier term shows up as a count on the wrong counter or in the wrong mode. Counters are loaded with values just below a 32-bit boundary, which separates a correct carry into the high half from a low half that wraps alone. One write to a counter lands on the same edge as an event on that counter, which shows whether the write has priority. Writes and events aimed at the absent slots confirm that those slots stay at zero.

// File: rtl/pcb_pkg.sv
// Shared constants for the performance counter bank.
// These are the control-word bit positions and the control-space word addresses.
package pcb_pkg;
    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_SUP_BIT   = 2;
    localparam int CTRL_USR_BIT   = 3;
    localparam int CTRL_CLREN_BIT = 30;
    localparam int CTRL_CLRCNT_BIT = 31;

    localparam int CTRL_WORD_ADDR = 0;
    localparam int ENAB_WORD_ADDR = 1;

    localparam logic SPACE_CTRL = 1'b0;
    localparam logic SPACE_CNT  = 1'b1;
endpackage

// File: rtl/pcb_ctrl.sv
// Control and count-enable registers. The module also forms the per-slot increment qualifiers.
// Assumes wr_ctrl is already decoded for the control space.
// Bits 31 and 30 are command bits that clear themselves and are never stored.
module pcb_ctrl #(
    parameter int          NUM_SLOTS = 32,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 6,
    parameter logic [31:0] IMPL_MASK = 32'h0FFF_FDFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 priv_sup,
    input  logic [NUM_SLOTS-1:0] evt_in,
    output logic [NUM_SLOTS-1:0] inc_vec,
    output logic                 clr_cnt,
    output logic [DATA_W-1:0]    ctrl_rdata
);
    import pcb_pkg::*;

    localparam logic [DATA_W-1:0]    STORE_MASK = {2'b00, {(DATA_W-2){1'b1}}};
    localparam logic [NUM_SLOTS-1:0] SLOT_MASK  = IMPL_MASK[NUM_SLOTS-1:0];

    logic [DATA_W-1:0]    ctrl_q;
    logic [NUM_SLOTS-1:0] enab_q;
    logic                 wr_ctrl_word;
    logic                 wr_enab_word;
    logic                 mode_ok;

    // decode which control-space word is written
    always_comb begin
        wr_ctrl_word = wr_ctrl && (addr == ADDR_W'(CTRL_WORD_ADDR));
        wr_enab_word = wr_ctrl && (addr == ADDR_W'(ENAB_WORD_ADDR));
        clr_cnt      = wr_ctrl_word && wr_data[CTRL_CLRCNT_BIT];
    end

    // control word storage; command bits are dropped
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl_word)
            ctrl_q <= wr_data & STORE_MASK;
    end

    // count-enable storage, limited to implemented slots, with bulk clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            enab_q <= '0;
        else if (wr_ctrl_word && wr_data[CTRL_CLREN_BIT])
            enab_q <= '0;
        else if (wr_enab_word)
            enab_q <= wr_data[NUM_SLOTS-1:0] & SLOT_MASK;
    end

    // qualify events by run bit, privilege permit and slot enable
    always_comb begin
        mode_ok = priv_sup ? ctrl_q[CTRL_SUP_BIT] : ctrl_q[CTRL_USR_BIT];
        inc_vec = evt_in & enab_q & {NUM_SLOTS{ctrl_q[CTRL_RUN_BIT] && mode_ok}};
    end

    // read mux for the control space
    always_comb begin
        ctrl_rdata = '0;
        if (addr == ADDR_W'(CTRL_WORD_ADDR))
            ctrl_rdata = ctrl_q;
        else if (addr == ADDR_W'(ENAB_WORD_ADDR))
            ctrl_rdata = DATA_W'(enab_q);
    end

    // R10
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_word && !wr_data[CTRL_RUN_BIT]) |=> (inc_vec == '0));

    // R7
    enab_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_word && wr_data[CTRL_CLREN_BIT]) |=> (enab_q == '0));

    // R4
    user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_sup && !ctrl_q[CTRL_USR_BIT]) |-> (inc_vec == '0));
endmodule

// File: rtl/pcb_counter.sv
// One 64-bit event counter with software-writable halves.
// Priority is clear, then a half write, then an increment.
// Assumes at most one half is written per cycle.
module pcb_counter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_q
);
    // counter state update
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (wr_lo)
            cnt_q[DATA_W-1:0] <= wr_data;
        else if (wr_hi)
            cnt_q[CNT_W-1:DATA_W] <= wr_data;
        else if (inc)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_lo && !wr_hi && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !wr_hi && !clr) |=> $stable(cnt_q));

    // R6
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !clr) |=> (cnt_q[DATA_W-1:0] == $past(wr_data)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/perf_counter_bank.sv
// Performance counter bank top.
// It decodes the word port into the two spaces, builds one counter per implemented slot, and muxes read data.
// Absent slots have no storage and read 0.
module perf_counter_bank #(
    parameter int          NUM_SLOTS = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] IMPL_MASK = 32'h0FFF_FDFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 space_sel,
    input  logic [5:0]           addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_SLOTS-1:0] evt_in,
    input  logic                 priv_sup
);
    import pcb_pkg::*;

    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 6;
    localparam int SLOT_W = ADDR_W - 1;

    logic [NUM_SLOTS-1:0] inc_vec;
    logic                 clr_cnt;
    logic [DATA_W-1:0]    ctrl_rdata;
    logic                 wr_ctrl;
    logic                 wr_cnt;
    logic [SLOT_W-1:0]    slot_idx;
    logic [CNT_W-1:0]     cnt_val [NUM_SLOTS];

    // split the port into space strobes and slot index
    always_comb begin
        wr_ctrl  = wr_en && (space_sel == SPACE_CTRL);
        wr_cnt   = wr_en && (space_sel == SPACE_CNT);
        slot_idx = addr[ADDR_W-1:1];
    end

    pcb_ctrl #(
        .NUM_SLOTS(NUM_SLOTS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .IMPL_MASK(IMPL_MASK)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .addr      (addr),
        .wr_data   (wr_data),
        .priv_sup  (priv_sup),
        .evt_in    (evt_in),
        .inc_vec   (inc_vec),
        .clr_cnt   (clr_cnt),
        .ctrl_rdata(ctrl_rdata)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (IMPL_MASK[s]) begin : g_impl
            logic hit;
            // this slot is addressed by a counter-space write
            always_comb hit = wr_cnt && (slot_idx == SLOT_W'(s));
            pcb_counter #(
                .DATA_W(DATA_W),
                .CNT_W (CNT_W)
            ) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (clr_cnt),
                .inc    (inc_vec[s]),
                .wr_lo  (hit && !addr[0]),
                .wr_hi  (hit && addr[0]),
                .wr_data(wr_data),
                .cnt_q  (cnt_val[s])
            );
        end else begin : g_absent
            assign cnt_val[s] = '0;
        end
    end

    // read mux across both spaces
    always_comb begin
        if (space_sel == SPACE_CTRL)
            rd_data = ctrl_rdata;
        else if (addr[0])
            rd_data = cnt_val[slot_idx][CNT_W-1:DATA_W];
        else
            rd_data = cnt_val[slot_idx][DATA_W-1:0];
    end

    // R8
    absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (space_sel == SPACE_CNT && !IMPL_MASK[slot_idx]) |-> (rd_data == '0));
endmodule

// File: tb/perf_counter_bank_test.sv
// Directed bench for the performance counter bank.
module perf_counter_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        space_sel = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] evt_in = '0;
    logic        priv_sup = 1'b1;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] IMPL = 32'h0FFF_FDFE;

    always #2.5 clk = ~clk;

    perf_counter_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .space_sel(space_sel),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .evt_in(evt_in), .priv_sup(priv_sup)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sp, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        space_sel = sp; addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sp, input logic [5:0] a, output logic [31:0] d);
        space_sel = sp; addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic [31:0] mask, input int n);
        @(negedge clk);
        evt_in = mask;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 0, v); chk("R1 ctrl", v, 0);
        rd(0, 1, v); chk("R1 enab", v, 0);
        rd(1, 2, v); chk("R1 cnt1 lo", v, 0);
        rd(1, 3, v); chk("R1 cnt1 hi", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        wr(0, 1, 32'hFFFF_FFFF);
        rd(0, 1, v); chk("R5 R8 enab readback", v, IMPL);
        wr(0, 0, 32'h0000_000D);
        pulse(32'h0000_0022, 10);
        rd(1, 2, v);  chk("R3 cnt1", v, 10);
        rd(1, 10, v); chk("R2 R3 cnt5", v, 10);
        rd(1, 4, v);  chk("R3 cnt2 idle", v, 0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        wr(0, 0, 32'h0000_0005);
        priv_sup = 1'b0;
        pulse(32'h0000_0004, 4);
        rd(1, 4, v); chk("R4 user blocked", v, 0);
        priv_sup = 1'b1;
        pulse(32'h0000_0004, 3);
        rd(1, 4, v); chk("R4 supervisor counts", v, 3);
        wr(0, 0, 32'h0000_0009);
        priv_sup = 1'b0;
        pulse(32'h0000_0004, 2);
        rd(1, 4, v); chk("R4 user counts", v, 5);
        priv_sup = 1'b1;
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(0, 0, 32'h0000_000D);
        rd(0, 1, v);
        wr(0, 1, v & ~32'h8);
        pulse(32'h0000_000A, 5);
        rd(1, 6, v); chk("R5 cnt3 disabled", v, 0);
        rd(1, 2, v); chk("R5 cnt1 still counts", v, 15);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(0, 0, 32'h0000_0002);
        pulse(32'h0000_0002, 5);
        rd(1, 2, v); chk("R10 halted", v, 15);
        rd(0, 0, v); chk("R10 ctrl readback", v, 32'h2);
    endtask

    task automatic t_load_carry();
        logic [31:0] v;
        wr(0, 0, 32'h0000_000D);
        wr(1, 8, 32'hFFFF_FFFE);
        wr(1, 9, 32'h0000_0012);
        rd(1, 8, v); chk("R6 load lo", v, 32'hFFFF_FFFE);
        rd(1, 9, v); chk("R2 R6 load hi", v, 32'h12);
        pulse(32'h0000_0010, 3);
        rd(1, 8, v); chk("R9 lo after carry", v, 1);
        rd(1, 9, v); chk("R9 hi after carry", v, 32'h13);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        @(negedge clk);
        evt_in = 32'h40; space_sel = 1; addr = 12; wr_data = 100; wr_en = 1;
        @(negedge clk);
        wr_en = 0; evt_in = 0;
        rd(1, 12, v); chk("R6 write beats increment", v, 100);
        pulse(32'h40, 2);
        rd(1, 12, v); chk("R6 counts after load", v, 102);
    endtask

    task automatic t_absent();
        logic [31:0] v;
        wr(1, 18, 32'h55);
        wr(1, 0, 32'h66);
        wr(1, 57, 32'h77);
        pulse(32'hF000_0201, 4);
        rd(1, 18, v); chk("R8 slot9 lo", v, 0);
        rd(1, 0, v);  chk("R8 slot0 lo", v, 0);
        rd(1, 57, v); chk("R8 slot28 hi", v, 0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(0, 0, 32'h8000_000D);
        rd(1, 2, v);  chk("R7 cnt1 cleared", v, 0);
        rd(1, 9, v);  chk("R7 cnt4 hi cleared", v, 0);
        rd(0, 0, v);  chk("R7 ctrl readback", v, 32'hD);
        rd(0, 1, v);  chk("R7 enab kept", v, IMPL & ~32'h8);
        wr(0, 0, 32'h4000_000D);
        rd(0, 1, v);  chk("R7 enab cleared", v, 0);
        rd(0, 0, v);  chk("R7 ctrl readback 2", v, 32'hD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_mode();
        t_enable();
        t_stop();
        t_load_carry();
        t_priority();
        t_absent();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule